// File: doc/BRIEF.md
# Two-Wire Bus Target Byte Engine

This block is the target side of a two-wire serial bus (clock line and data line, both open-drain). It operates at the byte level. It watches the bus for start and stop conditions and takes in a 7-bit address followed by a direction bit. When the address is its own, it either collects bytes from the controller or sends bytes to it. Each byte is followed by a ninth clock that carries the acknowledge bit. The pads are modelled as separate line inputs plus drive-low enables. Both line inputs pass through a two-flop synchroniser, and all bus edges are detected in the system clock domain. The system clock must run well above the bus clock.

On the local side, received bytes leave through a valid/ready port and bytes to transmit arrive through a second valid/ready port. When the local side has not yet taken a received byte, or has not yet supplied the next byte to send, the engine holds the clock line low. This makes the controller wait. An `accept` flag decides whether the engine serves a transfer at all. It is sampled when the address byte completes and when each written byte completes. When it is low, the engine answers with not-acknowledge and stays off the bus until the next start or stop.

States and transitions:
- IDLE leaves only on a start.
- ADDR shifts in 8 bits on rising clock edges. On the falling edge after bit 8 it moves to ADDR_ACK (address matches and accept is high) or to IGNORE (otherwise).
- ADDR_ACK holds the data line low for the ninth clock. On its falling edge it moves to WR_BIT for a write or RD_FETCH for a read.
- WR_BIT shifts in 8 bits. On the falling edge after bit 8 it moves to WR_HOLD (accept high) or IGNORE (accept low).
- WR_HOLD stretches the clock until the byte is taken, then moves to WR_ACK.
- WR_ACK holds the data line low through the ninth clock and returns to WR_BIT.
- RD_FETCH stretches the clock until a byte is supplied, then moves to RD_BIT.
- RD_BIT drives 8 bits and moves to RD_ACK after the eighth falling edge.
- RD_ACK samples the controller's bit. It returns to RD_FETCH on acknowledge and moves to IGNORE on not-acknowledge.
- IGNORE drives nothing.
- From any state, a start goes to ADDR and a stop goes to IDLE.

Top module: `twi_target_core`

## Requirements
- R1: After reset, and whenever idle, the engine releases both lines (`scl_pull`=0, `sda_pull`=0), and `wr_valid` and `rd_ready` are 0.
- R2: The address byte arrives MSB first: seven address bits, then a direction bit (1 = read). If the address equals `OWN_ADDR` and `accept` is 1, the engine pulls the data line low for the ninth clock. Otherwise it leaves the data line released and ignores the bus until the next start or stop.
- R3: Written bytes are assembled MSB first. Each byte is presented on `wr_data` with `wr_valid` held, and `wr_data` stable, until `wr_ready`. Any number of bytes may follow one address.
- R4: After the eighth clock of a written byte, the clock line is held low until the local side accepts the byte. The acknowledge is driven only after that.
- R5: If `accept` is 0 when a written byte completes, the byte is not presented and the data line stays released on the ninth clock (not-acknowledge). Later bytes are then ignored until a start or stop.
- R6: On a read, after the address acknowledge and after each controller acknowledge, `rd_ready` is raised and the clock line is held low until `rd_valid`. The byte is then driven MSB first, and the data line changes only while the clock line is low.
- R7: After a controller not-acknowledge on a read byte, the engine releases the data line, requests no further byte, and reads back as all ones until the next start.
- R8: A data-line fall while the clock line is high (start) restarts address reception from any state, so a repeated start works without a stop.
- R9: A data-line rise while the clock line is high (stop) returns the engine to idle with both lines released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Clock line level from the pad |
| sda_in | input | 1 | Data line level from the pad |
| scl_pull | output | 1 | Drive the clock line low (stretch) |
| sda_pull | output | 1 | Drive the data line low |
| accept | input | 1 | Local side willing to serve; 0 forces not-acknowledge |
| wr_data | output | 8 | Byte received from the controller |
| wr_valid | output | 1 | Received byte waiting |
| wr_ready | input | 1 | Local side takes the received byte |
| rd_data | input | 8 | Byte to send to the controller |
| rd_valid | input | 1 | Byte to send is available |
| rd_ready | output | 1 | Engine requests the next byte to send |

## Verification
A wrong state shows up on the bus within one byte time. A missed or extra bit count moves the acknowledge to the wrong clock. The controller then reads a shifted byte or a missing acknowledge on the very next ninth clock. A stuck stretch state keeps `scl_pull` high, and the controller's next clock edge never arrives. A fault in the handling of start, stop or ignore leaves a line pulled, or produces an acknowledge where a not-acknowledge was due. Both are visible at the first byte after the condition.

// File: rtl/twi_tgt_pkg.sv
package twi_tgt_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_WR_BIT,
        S_WR_HOLD,
        S_WR_ACK,
        S_RD_FETCH,
        S_RD_BIT,
        S_RD_ACK,
        S_IGNORE
    } tgt_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_byte_shifter.sv
module twi_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    input  logic         shift_bit,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift_en)
            q <= {q[W-2:0], shift_bit};
    end
endmodule

// File: rtl/twi_target_core.sv
module twi_target_core
    import twi_tgt_pkg::*;
#(
    parameter logic [BYTE_W-2:0] OWN_ADDR    = 7'h2A,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic              accept,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic              rd_ready
);
    localparam int                CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BYTE_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    tgt_state_e        st, st_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              rw, rw_n;
    logic              mack, mack_n;
    logic              sh_load, sh_shift, sh_bit;
    logic [BYTE_W-1:0] sh_q;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_byte_shifter #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_val  (rd_data),
        .shift_en  (sh_shift),
        .shift_bit (sh_bit),
        .q         (sh_q)
    );

    // next-state and datapath control
    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        rw_n     = rw;
        mack_n   = mack;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_bit   = sda_s;
        if (start_det) begin
            st_n  = S_ADDR;
            cnt_n = '0;
        end else if (stop_det) begin
            st_n = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE: ;
                S_ADDR: begin
                    if (scl_rise) begin
                        sh_shift = 1'b1;
                        cnt_n    = cnt + 1'b1;
                    end else if (scl_fall && cnt == CNT_FULL) begin
                        if (sh_q[BYTE_W-1:1] == OWN_ADDR && accept) begin
                            st_n = S_ADDR_ACK;
                            rw_n = sh_q[0];
                        end else begin
                            st_n = S_IGNORE;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_n = '0;
                        st_n  = rw ? S_RD_FETCH : S_WR_BIT;
                    end
                end
                S_WR_BIT: begin
                    if (scl_rise) begin
                        sh_shift = 1'b1;
                        cnt_n    = cnt + 1'b1;
                    end else if (scl_fall && cnt == CNT_FULL) begin
                        st_n = accept ? S_WR_HOLD : S_IGNORE;
                    end
                end
                S_WR_HOLD: begin
                    if (wr_ready) st_n = S_WR_ACK;
                end
                S_WR_ACK: begin
                    if (scl_fall) begin
                        cnt_n = '0;
                        st_n  = S_WR_BIT;
                    end
                end
                S_RD_FETCH: begin
                    if (rd_valid) begin
                        sh_load = 1'b1;
                        cnt_n   = '0;
                        st_n    = S_RD_BIT;
                    end
                end
                S_RD_BIT: begin
                    if (scl_fall) begin
                        sh_shift = 1'b1;
                        sh_bit   = 1'b1;
                        if (cnt == CNT_LAST) st_n = S_RD_ACK;
                        else                 cnt_n = cnt + 1'b1;
                    end
                end
                S_RD_ACK: begin
                    if (scl_rise)      mack_n = ~sda_s;
                    else if (scl_fall) st_n = mack ? S_RD_FETCH : S_IGNORE;
                end
                S_IGNORE: ;
                default: st_n = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            cnt  <= '0;
            rw   <= 1'b0;
            mack <= 1'b0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            rw   <= rw_n;
            mack <= mack_n;
        end
    end

    // outputs decoded from state
    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        wr_valid = 1'b0;
        rd_ready = 1'b0;
        unique case (st)
            S_ADDR_ACK, S_WR_ACK: sda_pull = 1'b1;
            S_WR_HOLD: begin
                scl_pull = 1'b1;
                wr_valid = 1'b1;
            end
            S_RD_FETCH: begin
                scl_pull = 1'b1;
                rd_ready = 1'b1;
            end
            S_RD_BIT: sda_pull = ~sh_q[BYTE_W-1];
            default: ;
        endcase
    end

    assign wr_data = sh_q;
endmodule

// File: rtl/twi_target_chk.sv
module twi_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_pull,
    input logic       sda_pull,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic [7:0] wr_data,
    input logic       rd_ready,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det
);
    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));

    // R4
    wr_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> scl_pull);

    // R6
    rd_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> scl_pull && !sda_pull);

    // R6
    sda_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !$past(scl_s));

    // R8
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !scl_pull && !sda_pull);

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !scl_pull && !sda_pull && !wr_valid && !rd_ready);
endmodule

bind twi_target_core twi_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_data   (wr_data),
    .rd_ready  (rd_ready),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/sim_twi_target_core.sv
module sim_twi_target_core;
    localparam logic [6:0] MY_ADDR = 7'h2A;
    localparam int HALF = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_line, sda_line;
    logic scl_pull, sda_pull, wr_valid, rd_ready;
    logic accept = 1'b1, wr_ready = 1'b0, rd_valid = 1'b0;
    logic [7:0] wr_data, rd_data = 8'h00;

    assign scl_line = !(m_scl_low || scl_pull);
    assign sda_line = !(m_sda_low || sda_pull);

    twi_target_core #(.OWN_ADDR(MY_ADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .accept(accept),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
    );

    int n_tests = 0, n_fail = 0;
    int wr_delay = 0, rd_delay = 0, wcnt = 0, rcnt = 0;
    int rx_n = 0, rd_idx = 0, cur_str = 0, max_str = 0;
    logic [7:0] rx_log [0:15];
    logic [7:0] rd_src [0:7];
    bit done = 0;

    // local-side responder
    always @(negedge clk) begin
        if (wr_ready) wr_ready = 1'b0;
        else if (wr_valid) begin
            if (wcnt >= wr_delay) begin
                wr_ready = 1'b1;
                if (rx_n < 16) rx_log[rx_n] = wr_data;
                rx_n++;
                wcnt = 0;
            end else wcnt++;
        end
        if (rd_valid) begin
            rd_valid = 1'b0;
            rd_idx++;
        end else if (rd_ready) begin
            if (rcnt >= rd_delay) begin
                rd_data  = rd_src[rd_idx];
                rd_valid = 1'b1;
                rcnt = 0;
            end else rcnt++;
        end
        if (scl_pull) cur_str++;
        else begin
            if (cur_str > max_str) max_str = cur_str;
            cur_str = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic half_t(); repeat (HALF) @(negedge clk); endtask
    task automatic wait_high(); while (!scl_line) @(negedge clk); endtask

    task automatic m_start();
        repeat (2) @(negedge clk);
        m_sda_low = 1'b0; half_t();
        m_scl_low = 1'b0; @(negedge clk); wait_high(); half_t();
        m_sda_low = 1'b1; half_t();
        m_scl_low = 1'b1;
    endtask

    task automatic m_stop();
        repeat (2) @(negedge clk);
        m_sda_low = 1'b1; half_t();
        m_scl_low = 1'b0; @(negedge clk); wait_high(); half_t();
        m_sda_low = 1'b0; half_t();
    endtask

    task automatic m_bit(input logic b, output logic r);
        repeat (2) @(negedge clk);
        m_sda_low = !b; half_t();
        m_scl_low = 1'b0; @(negedge clk); wait_high();
        repeat (HALF/2) @(negedge clk);
        r = sda_line;
        repeat (HALF/2) @(negedge clk);
        m_scl_low = 1'b1;
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(d[i], r);
        m_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            d[i] = r;
        end
        m_bit(!give_ack, r);
    endtask

    task automatic t_reset();
        chk("R1 scl_pull", scl_pull, 0);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 wr_valid/rd_ready", {wr_valid, rd_ready}, 0);
    endtask

    task automatic t_write();
        logic a;
        rx_n = 0; wr_delay = 0; accept = 1'b1;
        m_start();
        m_wbyte({MY_ADDR, 1'b0}, a); chk("R2 address ack", a, 1);
        m_wbyte(8'hA5, a); chk("R3 ack byte0", a, 1);
        m_wbyte(8'h3C, a); chk("R3 ack byte1", a, 1);
        m_wbyte(8'h01, a); chk("R3 ack byte2", a, 1);
        m_stop();
        chk("R3 byte count", rx_n, 3);
        chk("R3 byte0", rx_log[0], 8'hA5);
        chk("R3 byte1", rx_log[1], 8'h3C);
        chk("R3 byte2", rx_log[2], 8'h01);
        half_t();
        chk("R9 idle after stop", {scl_pull, sda_pull, wr_valid, rd_ready}, 0);
    endtask

    task automatic t_write_stretch();
        logic a;
        rx_n = 0; wr_delay = 40; max_str = 0;
        m_start();
        m_wbyte({MY_ADDR, 1'b0}, a);
        m_wbyte(8'h96, a); chk("R4 ack after stretch", a, 1);
        m_stop();
        chk("R4 stretch length", max_str >= 40, 1);
        chk("R4 byte", rx_log[0], 8'h96);
        wr_delay = 0;
    endtask

    task automatic t_addr_miss();
        logic a;
        rx_n = 0;
        m_start();
        m_wbyte({7'h15, 1'b0}, a); chk("R2 foreign address nack", a, 0);
        m_wbyte(8'h55, a); chk("R2 ignored byte nack", a, 0);
        m_stop();
        chk("R2 nothing presented", rx_n, 0);
        accept = 1'b0;
        m_start();
        m_wbyte({MY_ADDR, 1'b0}, a); chk("R2 not accepting nack", a, 0);
        m_stop();
        accept = 1'b1;
    endtask

    task automatic t_refuse();
        logic a;
        rx_n = 0; accept = 1'b1;
        m_start();
        m_wbyte({MY_ADDR, 1'b0}, a);
        m_wbyte(8'h42, a); chk("R5 first byte ack", a, 1);
        accept = 1'b0;
        m_wbyte(8'h43, a); chk("R5 refused byte nack", a, 0);
        accept = 1'b1;
        m_wbyte(8'h44, a); chk("R5 later byte ignored", a, 0);
        m_stop();
        chk("R5 only first presented", rx_n, 1);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] d;
        rd_src[0] = 8'h81; rd_src[1] = 8'h7E; rd_src[2] = 8'hC3;
        rd_idx = 0; rd_delay = 25; max_str = 0;
        m_start();
        m_wbyte({MY_ADDR, 1'b1}, a); chk("R2 read address ack", a, 1);
        m_rbyte(1'b1, d); chk("R6 read byte0", d, 8'h81);
        m_rbyte(1'b1, d); chk("R6 read byte1", d, 8'h7E);
        m_rbyte(1'b0, d); chk("R6 read byte2", d, 8'hC3);
        chk("R6 fetch stretch", max_str >= 25, 1);
        m_rbyte(1'b0, d); chk("R7 released after nack", d, 8'hFF);
        chk("R7 no further fetch", rd_idx, 3);
        m_stop();
        rd_delay = 0;
    endtask

    task automatic t_restart();
        logic a;
        logic [7:0] d;
        rx_n = 0; rd_idx = 0; rd_src[0] = 8'h5A;
        m_start();
        m_wbyte({MY_ADDR, 1'b0}, a);
        m_wbyte(8'h11, a); chk("R8 byte before restart", a, 1);
        m_start();
        m_wbyte({MY_ADDR, 1'b1}, a); chk("R8 address after restart", a, 1);
        m_rbyte(1'b0, d); chk("R8 read after restart", d, 8'h5A);
        m_stop();
        chk("R8 write kept", rx_log[0], 8'h11);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_write_stretch();
        t_addr_miss();
        t_refuse();
        t_read();
        t_restart();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule